// File: doc/BRIEF.md
# Saturating Trim Code Controller

This block owns an 8-bit trim code that steers an external digital-to-analog stage. Software or a production tester nudges the code one step at a time with count-up and count-down event pulses, and commits it with a program-request pulse that writes the code into a one-byte non-volatile store through a request/busy handshake. The code can only be moved while the enable pin is high; the enable pin is asynchronous and passes through a synchronizer whose rising and falling edges act as separate one-cycle strobes.

At power-up, and again whenever enable falls, the controller reads the stored byte back into the code register, so a committed value always reappears once adjustment ends. Several guards make stray pulses harmless. The first count pulse after enable rises is discarded, as is the first after each program operation. Count pulses in a settling window just after enable rises are dropped outright. Every event is dropped while a memory operation is under way. The code clamps at both ends of its range.

Top module: `trim_ctrl`

## Requirements
- R1: The code never wraps. A count-up at 255 leaves 255, a count-down at 0 leaves 0, and apart from a memory load the code moves by at most one per cycle.
- R2: While the synchronized enable is low, count-up, count-down and program pulses change neither the code nor the stored byte.
- R3: The first count pulse accepted after enable rises is discarded. Later pulses step the code by one: count-up adds 1, count-down subtracts 1.
- R4: The first count pulse after a program operation completes is discarded, and the one after it steps the code.
- R5: A program pulse while enabled and idle issues one memory request with write-enable high and the current code as write data. The request is a single-cycle pulse, is raised only while the memory reports not busy, and a second program pulse during the operation starts no second write.
- R6: A falling edge of enable starts a read of the stored byte, and the code takes that byte when the read finishes. `busy_o` is high a few cycles after the fall.
- R7: Out of reset the code holds mid-scale 128 and `busy_o` is high. A read of the stored byte starts by itself and loads the code.
- R8: For HOLD_CYC cycles after the synchronized enable rises, count pulses are dropped, and they do not use up the discard of R3.
- R9: `busy_o` is high from the start of a memory operation until it completes. Count and program pulses that arrive while it is high are dropped.
- R10: A count-up and a count-down in the same cycle cancel, leaving the code and the discard state unchanged.
- R11: A program pulse and a count pulse in the same cycle: the program wins, the count is dropped, and the code before that cycle is what gets written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_i | input | 1 | Asynchronous adjustment enable pin |
| up_i | input | 1 | One-cycle count-up event |
| dn_i | input | 1 | One-cycle count-down event |
| prog_i | input | 1 | One-cycle program-request event |
| code_o | output | CODE_W | Current trim code |
| busy_o | output | 1 | Memory operation pending or under way |
| nvm_req_o | output | 1 | One-cycle memory operation request |
| nvm_we_o | output | 1 | Operation kind: 1 write, 0 read |
| nvm_wdata_o | output | CODE_W | Byte to write |
| nvm_busy_i | input | 1 | Memory busy; its fall ends the operation |
| nvm_rdata_i | input | CODE_W | Stored byte, valid when busy falls after a read |

## Verification
The bench starts from a stored byte that differs from mid-scale, so a missing power-up load and a missing reload on enable fall both show as a wrong code. Pairs of count pulses after each enable rise and each program separate a design that discards the first pulse from one that does not. A pulse sent inside the settling window, followed by a pair after it, shows whether that early pulse was dropped or wrongly used up the discard. Long runs past 255 and below 0 expose wrap-around. Simultaneous up/down, program-with-count, and pulses sent while busy or disabled are then checked for having no effect on the code or on the memory's write count.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_ACK  = 2'd2,
    SQ_RUN  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/trim_en_sync.sv
module trim_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic en_lvl,
  output logic en_rise,
  output logic en_fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], en_i};
  end

  assign en_lvl  = sh_q[STAGES-1];
  assign en_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign en_fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/trim_counter.sv
module trim_counter #(
  parameter int CODE_W   = 8,
  parameter int HOLD_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              gate_ok,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              arm_skip,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  output logic [CODE_W-1:0] code_o,
  output logic              hold_act
);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CODE_W-1:0] MAXV = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MIDV = {1'b1, {(CODE_W-1){1'b0}}};

  logic [HW-1:0] hold_q;
  logic          skip_q;
  logic          step, acc;

  assign hold_act = (hold_q != '0);
  assign step     = up_i ^ dn_i;
  assign acc      = en_lvl & ~en_rise & gate_ok & ~hold_act & step;

  always_ff @(posedge clk) begin
    if (rst)                  hold_q <= '0;
    else if (en_rise)         hold_q <= HW'(HOLD_CYC);
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       skip_q <= 1'b0;
    else if (en_rise || arm_skip)  skip_q <= 1'b1;
    else if (acc)                  skip_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= MIDV;
    end else if (load) begin
      code_o <= load_val;
    end else if (acc && !skip_q) begin
      if (up_i && code_o != MAXV)      code_o <= code_o + 1'b1;
      else if (dn_i && code_o != '0)   code_o <= code_o - 1'b1;
    end
  end
endmodule

// File: rtl/trim_nvm_seq.sv
module trim_nvm_seq #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_lvl,
  input  logic              en_fall,
  input  logic              prog_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              nvm_busy_i,
  input  logic [CODE_W-1:0] nvm_rdata_i,
  output logic              busy_o,
  output logic              nvm_req_o,
  output logic              nvm_we_o,
  output logic [CODE_W-1:0] nvm_wdata_o,
  output logic              load_stb,
  output logic [CODE_W-1:0] load_val,
  output logic              wr_done
);
  import trim_pkg::*;

  seq_st_t st_q;
  logic    pend_rd_q;
  logic    finish;

  assign busy_o    = (st_q != SQ_IDLE) | pend_rd_q;
  assign nvm_req_o = (st_q == SQ_REQ);
  assign finish    = (st_q == SQ_RUN) & ~nvm_busy_i;
  assign load_stb  = finish & ~nvm_we_o;
  assign wr_done   = finish & nvm_we_o;
  assign load_val  = nvm_rdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      pend_rd_q   <= 1'b1;
      nvm_we_o    <= 1'b0;
      nvm_wdata_o <= '0;
    end else begin
      if (en_fall) pend_rd_q <= 1'b1;
      unique case (st_q)
        SQ_IDLE: begin
          if (pend_rd_q && !en_fall) begin
            pend_rd_q <= 1'b0;
            nvm_we_o  <= 1'b0;
            st_q      <= SQ_REQ;
          end else if (prog_i && en_lvl && !busy_o) begin
            nvm_we_o    <= 1'b1;
            nvm_wdata_o <= code_i;
            st_q        <= SQ_REQ;
          end
        end
        SQ_REQ:  st_q <= SQ_ACK;
        SQ_ACK:  if (nvm_busy_i)  st_q <= SQ_RUN;
        SQ_RUN:  if (!nvm_busy_i) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl #(
  parameter int CODE_W   = 8,
  parameter int HOLD_CYC = 10000,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              prog_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              nvm_req_o,
  output logic              nvm_we_o,
  output logic [CODE_W-1:0] nvm_wdata_o,
  input  logic              nvm_busy_i,
  input  logic [CODE_W-1:0] nvm_rdata_i
);
  logic              en_lvl, en_rise, en_fall;
  logic              load_stb, wr_done, hold_act;
  logic [CODE_W-1:0] load_val;

  trim_en_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .en_i(en_i),
    .en_lvl(en_lvl), .en_rise(en_rise), .en_fall(en_fall)
  );

  trim_counter #(.CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC)) u_cnt (
    .clk(clk), .rst(rst), .en_lvl(en_lvl), .en_rise(en_rise),
    .gate_ok(~busy_o & ~prog_i), .up_i(up_i), .dn_i(dn_i),
    .arm_skip(wr_done), .load(load_stb), .load_val(load_val),
    .code_o(code_o), .hold_act(hold_act)
  );

  trim_nvm_seq #(.CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst(rst), .en_lvl(en_lvl), .en_fall(en_fall),
    .prog_i(prog_i), .code_i(code_o), .nvm_busy_i(nvm_busy_i),
    .nvm_rdata_i(nvm_rdata_i), .busy_o(busy_o), .nvm_req_o(nvm_req_o),
    .nvm_we_o(nvm_we_o), .nvm_wdata_o(nvm_wdata_o), .load_stb(load_stb),
    .load_val(load_val), .wr_done(wr_done)
  );
endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en_lvl,
  input logic              busy_o,
  input logic              load_stb,
  input logic              hold_act,
  input logic              nvm_req_o,
  input logic              nvm_busy_i,
  input logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MAXV = {CODE_W{1'b1}};

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    ($past(code_o) == MAXV && !$past(load_stb)) |-> code_o != '0); // R1

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_stb) && code_o != $past(code_o)) |->
      ({1'b0, code_o} == {1'b0, $past(code_o)} + 1'b1 ||
       {1'b0, code_o} + 1'b1 == {1'b0, $past(code_o)})); // R1

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_lvl) && !$past(load_stb)) |-> code_o == $past(code_o)); // R2

  AST_REQ_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
    nvm_req_o |-> !nvm_busy_i); // R5

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    nvm_req_o |=> !nvm_req_o); // R5

  AST_HOLDOFF_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_act) && !$past(load_stb)) |-> code_o == $past(code_o)); // R8

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && !$past(load_stb)) |-> code_o == $past(code_o)); // R9

  AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
    nvm_req_o |-> busy_o); // R9
endmodule

bind trim_ctrl trim_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .en_lvl(en_lvl), .busy_o(busy_o),
  .load_stb(load_stb), .hold_act(hold_act), .nvm_req_o(nvm_req_o),
  .nvm_busy_i(nvm_busy_i), .code_o(code_o)
);

// File: tb/sim_trim_ctrl.sv
`timescale 1ns/1ps
module sim_trim_ctrl;
  localparam int CW   = 8;
  localparam int HOLD = 40;
  localparam int LAT  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, up_i = 1'b0, dn_i = 1'b0, prog_i = 1'b0;
  logic [CW-1:0] code_o, nvm_wdata_o;
  logic busy_o, nvm_req_o, nvm_we_o;
  logic nvm_busy_i = 1'b0;
  logic [CW-1:0] nvm_rdata_i = '0;

  int errors = 0, checks = 0, cyc = 0;
  int n_wr = 0, n_rd = 0, lat_cnt = 0;
  logic we_l = 1'b0;
  logic [CW-1:0] wdata_l = '0;
  logic [CW-1:0] mem = 8'd77;

  always #2.5 clk = ~clk;

  trim_ctrl #(.CODE_W(CW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .up_i(up_i), .dn_i(dn_i),
    .prog_i(prog_i), .code_o(code_o), .busy_o(busy_o),
    .nvm_req_o(nvm_req_o), .nvm_we_o(nvm_we_o), .nvm_wdata_o(nvm_wdata_o),
    .nvm_busy_i(nvm_busy_i), .nvm_rdata_i(nvm_rdata_i)
  );

  // Memory model: busy for LAT cycles, result visible when busy falls.
  always @(posedge clk) begin
    if (nvm_req_o && !nvm_busy_i) begin
      nvm_busy_i <= 1'b1;
      lat_cnt    <= LAT;
      we_l       <= nvm_we_o;
      wdata_l    <= nvm_wdata_o;
    end else if (nvm_busy_i) begin
      if (lat_cnt == 1) begin
        nvm_busy_i <= 1'b0;
        if (we_l) begin mem <= wdata_l; n_wr <= n_wr + 1; end
        else begin nvm_rdata_i <= mem; n_rd <= n_rd + 1; end
      end
      lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      report();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(logic u, logic d, logic p);
    up_i = u; dn_i = d; prog_i = p;
    @(negedge clk);
    up_i = 1'b0; dn_i = 1'b0; prog_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    idle(3);
    while (busy_o) @(negedge clk);
    idle(1);
  endtask

  task automatic t_reset();
    idle(1);
    chk("R7 mid-scale out of reset", code_o, 128);
    chk("R7 busy after reset", busy_o, 1);
    wait_idle();
    chk("R7 stored byte loaded", code_o, 77);
    chk("R7 one read", n_rd, 1);
  endtask

  task automatic t_enable();
    en_i = 1'b1;
    idle(HOLD + 10);
    pulse(1, 0, 0);
    chk("R3 first pulse discarded", code_o, 77);
    pulse(1, 0, 0);
    chk("R3 up steps", code_o, 78);
    pulse(0, 1, 0);
    chk("R3 down steps", code_o, 77);
    pulse(1, 1, 0);
    chk("R10 up+down cancel", code_o, 77);
  endtask

  task automatic t_program();
    up_i = 1'b0; prog_i = 1'b1;
    @(negedge clk); prog_i = 1'b0;
    idle(3);
    chk("R9 busy during write", busy_o, 1);
    pulse(1, 0, 0);
    pulse(0, 0, 1);
    wait_idle();
    chk("R9 pulse while busy dropped", code_o, 77);
    chk("R5 stored byte", mem, 77);
    chk("R5 single write", n_wr, 1);
    pulse(1, 0, 0);
    chk("R4 first pulse after program discarded", code_o, 77);
    pulse(1, 0, 0);
    chk("R4 next pulse steps", code_o, 78);
    pulse(1, 0, 1);
    wait_idle();
    chk("R11 count dropped with program", code_o, 78);
    chk("R11 pre-cycle code written", mem, 78);
    pulse(1, 0, 0);
    pulse(1, 0, 0);
    chk("R4 step after second program", code_o, 79);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 180; i++) pulse(1, 0, 0);
    chk("R1 clamp at 255", code_o, 255);
    for (int i = 0; i < 260; i++) pulse(0, 1, 0);
    chk("R1 clamp at 0", code_o, 0);
    pulse(1, 0, 0);
    chk("R1 up from 0", code_o, 1);
  endtask

  task automatic t_disable();
    en_i = 1'b0;
    idle(5);
    chk("R6 busy after enable fall", busy_o, 1);
    wait_idle();
    chk("R6 reload from store", code_o, 78);
    chk("R6 read count", n_rd, 2);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    pulse(0, 0, 1);
    idle(5);
    chk("R2 code frozen when disabled", code_o, 78);
    chk("R2 no write when disabled", n_wr, 2);
  endtask

  task automatic t_holdoff();
    en_i = 1'b1;
    idle(6);
    pulse(1, 0, 0);
    chk("R8 pulse in window dropped", code_o, 78);
    idle(HOLD + 10);
    pulse(1, 0, 0);
    chk("R8 window did not use discard", code_o, 78);
    pulse(1, 0, 0);
    chk("R8 step after window", code_o, 79);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_program();
    t_saturate();
    t_disable();
    t_holdoff();
    report();
  end
endmodule